// File: doc/BRIEF.md
# Address Translation Front-End with Abort Capture

This block sits between a core's memory request path and the two translation engines: a region-based protection checker and a page-table walker. It takes one access at a time, made up of a virtual address, an access kind (read, write or instruction fetch) and a privilege flag. It first relocates low addresses by a per-process offset. If translation is switched off in the control word, it answers at once with an identity mapping. Otherwise it hands the relocated address to whichever engine the configuration selects.

When an engine finishes, the block returns a mapping truncated to a 1 KB granule along with the read and write permissions. If the engine reports a fault, the block records the fault code and address in split instruction-side or data-side registers instead. It then raises exactly one abort strobe of the matching kind.

The engines themselves are outside this block. It sees them only through a start strobe and a completion handshake that carries the outcome.

Top module: `xlate_front`

## Requirements
- R1: An incoming virtual address strictly below 0x0200_0000 has `pid_offset` added to it (modulo 2^32) before any other use; an address at or above 0x0200_0000 is used unchanged. The relocated address is what the engines, the mapping and the fault address registers see.
- R2: When `ctrl_word` bit 0 is 0 at acceptance, the response comes one clock after the accepting edge. It carries `rsp_fault`=0, `rsp_rd`=1 and `rsp_wr`=1, with `rsp_vpage` = `rsp_ppage` = relocated address with bits [9:0] cleared. No engine strobe is issued.
- R3: When `ctrl_word` bit 0 is 1 and `cfg_region_prot` is 1, `mpu_go` pulses for exactly one cycle, one clock after acceptance. During that pulse `eng_vaddr`, `eng_kind` and `eng_user` hold the relocated address, the access kind and the privilege flag.
- R4: When `ctrl_word` bit 0 is 1 and `cfg_region_prot` is 0, `walk_go` pulses instead, with `walk_newfmt` equal to `ctrl_word` bit 23. Only one of `mpu_go` and `walk_go` is ever high.
- R5: One clock after the edge where `eng_done` is sampled high while busy, `rsp_valid` is high for one cycle. On success (`eng_fault`=0) it reports `rsp_vpage` = relocated address with bits [9:0] cleared, `rsp_ppage` = `eng_paddr` with bits [9:0] cleared, and `rsp_rd`/`rsp_wr` taken from the engine.
- R6: On a fault where the access kind is 2 (instruction fetch), `ifsr` takes the zero-extended `eng_code` and `ifar` takes the relocated address. `pabort` is raised with the response.
- R7: On a fault with access kind 0 (read), 1 (write) or 3 (treated as read), `dfsr` takes the zero-extended `eng_code` and `dfar` takes the relocated address. `dabort` is raised. If the kind is 1 and `cfg_newarch` is 1, `dfsr` bit 11 is also set.
- R8: The four fault registers reset to zero and change only on the response cycle of a fault of their own side.
- R9: At most one of `pabort`/`dabort` is high, only in a cycle where `rsp_valid` and `rsp_fault` are high, and for one cycle only.
- R10: `busy` is high from the clock after an enabled acceptance until the response. A `req_valid` seen while busy is ignored: the engine inputs do not change and no extra response appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request, taken when not busy |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 instruction fetch, 3 read |
| req_user | input | 1 | Unprivileged access |
| ctrl_word | input | 32 | Bit 0 translation enable, bit 23 newer table format |
| pid_offset | input | 32 | Per-process relocation offset |
| cfg_region_prot | input | 1 | Core uses region protection instead of page tables |
| cfg_newarch | input | 1 | Newer architecture: write flag in data fault status |
| busy | output | 1 | Waiting on an engine |
| mpu_go | output | 1 | Start strobe to region checker |
| walk_go | output | 1 | Start strobe to table walker |
| walk_newfmt | output | 1 | Walker table format select |
| eng_vaddr | output | 32 | Relocated address for the engines |
| eng_kind | output | 2 | Access kind for the engines |
| eng_user | output | 1 | Privilege flag for the engines |
| eng_done | input | 1 | Engine completion |
| eng_fault | input | 1 | Engine reports a fault |
| eng_code | input | CODE_W | Fault code |
| eng_paddr | input | 32 | Physical address on success |
| eng_rd | input | 1 | Read permitted |
| eng_wr | input | 1 | Write permitted |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 1 | Response is a fault |
| rsp_vpage | output | 32 | Virtual granule address |
| rsp_ppage | output | 32 | Physical granule address |
| rsp_rd | output | 1 | Read permission |
| rsp_wr | output | 1 | Write permission |
| pabort | output | 1 | Prefetch abort strobe |
| dabort | output | 1 | Data abort strobe |
| ifsr | output | 32 | Instruction fault status |
| ifar | output | 32 | Instruction fault address |
| dfsr | output | 32 | Data fault status |
| dfar | output | 32 | Data fault address |

## Verification
The assertions assume that the engines raise `eng_done` only while the block is busy, for a single cycle per start strobe. They also assume that the control word and straps are stable around acceptance. The stimulus models each engine as a responder that answers once after a chosen latency, including zero. It changes configuration only between requests. Requests held high during a busy period test the ignore rule, but completions are never issued outside a pending request.

// File: rtl/xlate_front.sv
module xlate_front #(
  parameter int CODE_W = 8,
  parameter logic [31:0] RELOC_LIMIT = 32'h0200_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       req_vaddr,
  input  logic [1:0]        req_kind,
  input  logic              req_user,
  input  logic [31:0]       ctrl_word,
  input  logic [31:0]       pid_offset,
  input  logic              cfg_region_prot,
  input  logic              cfg_newarch,
  output logic              busy,
  output logic              mpu_go,
  output logic              walk_go,
  output logic              walk_newfmt,
  output logic [31:0]       eng_vaddr,
  output logic [1:0]        eng_kind,
  output logic              eng_user,
  input  logic              eng_done,
  input  logic              eng_fault,
  input  logic [CODE_W-1:0] eng_code,
  input  logic [31:0]       eng_paddr,
  input  logic              eng_rd,
  input  logic              eng_wr,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [31:0]       rsp_vpage,
  output logic [31:0]       rsp_ppage,
  output logic              rsp_rd,
  output logic              rsp_wr,
  output logic              pabort,
  output logic              dabort,
  output logic [31:0]       ifsr,
  output logic [31:0]       ifar,
  output logic [31:0]       dfsr,
  output logic [31:0]       dfar
);
  localparam logic [31:0] GRAN_MASK = 32'hFFFF_FC00;
  localparam logic [1:0]  KIND_FETCH = 2'd2;
  localparam logic [1:0]  KIND_WRITE = 2'd1;
  localparam int          WR_FLAG_BIT = 11;

  logic [31:0] va_rel;
  logic        accept;
  logic [31:0] code_ext;

  assign va_rel    = (req_vaddr < RELOC_LIMIT) ? req_vaddr + pid_offset : req_vaddr;
  assign accept    = req_valid && !busy;
  assign code_ext  = 32'(eng_code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; mpu_go <= 1'b0; walk_go <= 1'b0; walk_newfmt <= 1'b0;
      eng_vaddr <= '0; eng_kind <= '0; eng_user <= 1'b0;
      rsp_valid <= 1'b0; rsp_fault <= 1'b0; rsp_vpage <= '0; rsp_ppage <= '0;
      rsp_rd <= 1'b0; rsp_wr <= 1'b0; pabort <= 1'b0; dabort <= 1'b0;
      ifsr <= '0; ifar <= '0; dfsr <= '0; dfar <= '0;
    end else begin
      mpu_go <= 1'b0; walk_go <= 1'b0;
      rsp_valid <= 1'b0; pabort <= 1'b0; dabort <= 1'b0;
      if (accept) begin
        eng_vaddr <= va_rel; eng_kind <= req_kind; eng_user <= req_user;
        if (!ctrl_word[0]) begin
          rsp_valid <= 1'b1; rsp_fault <= 1'b0;
          rsp_vpage <= va_rel & GRAN_MASK; rsp_ppage <= va_rel & GRAN_MASK;
          rsp_rd <= 1'b1; rsp_wr <= 1'b1;
        end else begin
          busy <= 1'b1;
          if (cfg_region_prot) mpu_go <= 1'b1;
          else begin
            walk_go <= 1'b1;
            walk_newfmt <= ctrl_word[23];
          end
        end
      end else if (busy && eng_done) begin
        busy <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_fault <= eng_fault;
        rsp_vpage <= eng_vaddr & GRAN_MASK;
        if (!eng_fault) begin
          rsp_ppage <= eng_paddr & GRAN_MASK;
          rsp_rd <= eng_rd; rsp_wr <= eng_wr;
        end else begin
          rsp_ppage <= '0; rsp_rd <= 1'b0; rsp_wr <= 1'b0;
          if (eng_kind == KIND_FETCH) begin
            ifsr <= code_ext; ifar <= eng_vaddr; pabort <= 1'b1;
          end else begin
            dfsr <= code_ext | (32'(eng_kind == KIND_WRITE && cfg_newarch) << WR_FLAG_BIT);
            dfar <= eng_vaddr; dabort <= 1'b1;
          end
        end
      end
    end
  end

  a_r4_one_engine: assert property (@(posedge clk) disable iff (!rst_n) !(mpu_go && walk_go));
  a_r3_mpu_pulse: assert property (@(posedge clk) disable iff (!rst_n) mpu_go |=> !mpu_go);
  a_r4_walk_pulse: assert property (@(posedge clk) disable iff (!rst_n) walk_go |=> !walk_go);
  a_r9_one_abort: assert property (@(posedge clk) disable iff (!rst_n) !(pabort && dabort));
  a_r9_abort_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (pabort || dabort) |-> (rsp_valid && rsp_fault));
  a_r9_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
    (pabort || dabort) |=> !(pabort || dabort));
  a_r8_ifr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pabort |-> ($stable(ifsr) && $stable(ifar)));
  a_r8_dfr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dabort |-> ($stable(dfsr) && $stable(dfar)));
  a_r10_eng_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(eng_vaddr) && $stable(eng_kind)));
  a_r3_go_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mpu_go || walk_go) |-> busy);
endmodule

// File: tb/xlate_front_test.sv
module xlate_front_test;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_user = 0, cfg_region_prot = 0, cfg_newarch = 0;
  logic [31:0] req_vaddr = 0, ctrl_word = 0, pid_offset = 0;
  logic [1:0] req_kind = 0;
  logic eng_done = 0, eng_fault = 0, eng_rd = 0, eng_wr = 0;
  logic [7:0] eng_code = 0;
  logic [31:0] eng_paddr = 0;
  logic busy, mpu_go, walk_go, walk_newfmt, eng_user, rsp_valid, rsp_fault, rsp_rd, rsp_wr;
  logic pabort, dabort;
  logic [1:0] eng_kind;
  logic [31:0] eng_vaddr, rsp_vpage, rsp_ppage, ifsr, ifar, dfsr, dfar;
  int checks = 0, errors = 0;
  logic [31:0] m_ifsr = 0, m_ifar = 0, m_dfsr = 0, m_dfar = 0;

  xlate_front uut (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_regs();
    chk(ifsr == m_ifsr, "R8 ifsr", ifsr, m_ifsr);
    chk(ifar == m_ifar, "R8 ifar", ifar, m_ifar);
    chk(dfsr == m_dfsr, "R8 dfsr", dfsr, m_dfsr);
    chk(dfar == m_dfar, "R8 dfar", dfar, m_dfar);
  endtask

  task automatic run(input logic [31:0] va, input logic [1:0] ty, input logic u,
                     input logic [31:0] ctl, input logic [31:0] pid, input logic mpu,
                     input logic v6, input int lat, input logic flt, input logic [7:0] code,
                     input logic [31:0] pa, input logic rd, input logic wr, input bit hold_req);
    logic [31:0] ea;
    ea = (va < 32'h0200_0000) ? va + pid : va;
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_kind = ty; req_user = u;
    ctrl_word = ctl; pid_offset = pid; cfg_region_prot = mpu; cfg_newarch = v6;
    @(negedge clk);
    if (hold_req) req_vaddr = va ^ 32'h0F00_0000; else req_valid = 0;
    if (!ctl[0]) begin
      req_valid = 0;
      chk(rsp_valid == 1, "R2 rsp_valid", rsp_valid, 1);
      chk(rsp_fault == 0, "R2 no fault", rsp_fault, 0);
      chk(rsp_vpage == (ea & 32'hFFFF_FC00), "R1 R2 vpage", rsp_vpage, ea & 32'hFFFF_FC00);
      chk(rsp_ppage == (ea & 32'hFFFF_FC00), "R2 ppage", rsp_ppage, ea & 32'hFFFF_FC00);
      chk(rsp_rd && rsp_wr, "R2 rd wr", {rsp_rd, rsp_wr}, 2'b11);
      chk(!mpu_go && !walk_go && !busy, "R2 no engine", {busy, mpu_go, walk_go}, 0);
    end else begin
      chk(busy == 1, "R10 busy", busy, 1);
      chk(rsp_valid == 0, "R5 no early rsp", rsp_valid, 0);
      if (mpu) chk(mpu_go && !walk_go, "R3 mpu_go", {mpu_go, walk_go}, 2'b10);
      else begin
        chk(walk_go && !mpu_go, "R4 walk_go", {mpu_go, walk_go}, 2'b01);
        chk(walk_newfmt == ctl[23], "R4 walk_newfmt", walk_newfmt, ctl[23]);
      end
      chk(eng_vaddr == ea, "R1 R3 eng_vaddr", eng_vaddr, ea);
      chk(eng_kind == ty && eng_user == u, "R3 kind user", {eng_kind, eng_user}, {ty, u});
      for (int k = 0; k < lat; k++) begin
        @(negedge clk);
        chk(!mpu_go && !walk_go, "R3 R4 single pulse", {mpu_go, walk_go}, 0);
        chk(rsp_valid == 0 && busy == 1, "R10 waiting", {rsp_valid, busy}, 2'b01);
        chk(eng_vaddr == ea, "R10 eng stable", eng_vaddr, ea);
        chk_regs();
      end
      eng_done = 1; eng_fault = flt; eng_code = code; eng_paddr = pa; eng_rd = rd; eng_wr = wr;
      @(negedge clk);
      eng_done = 0; req_valid = 0;
      chk(rsp_valid == 1, "R5 rsp_valid", rsp_valid, 1);
      chk(rsp_fault == flt, "R5 rsp_fault", rsp_fault, flt);
      chk(busy == 0, "R10 busy drop", busy, 0);
      if (!flt) begin
        chk(rsp_vpage == (ea & 32'hFFFF_FC00), "R5 vpage", rsp_vpage, ea & 32'hFFFF_FC00);
        chk(rsp_ppage == (pa & 32'hFFFF_FC00), "R5 ppage", rsp_ppage, pa & 32'hFFFF_FC00);
        chk(rsp_rd == rd && rsp_wr == wr, "R5 perms", {rsp_rd, rsp_wr}, {rd, wr});
        chk(!pabort && !dabort, "R9 no abort", {pabort, dabort}, 0);
      end else if (ty == 2) begin
        m_ifsr = {24'd0, code}; m_ifar = ea;
        chk(pabort && !dabort, "R6 pabort", {pabort, dabort}, 2'b10);
      end else begin
        m_dfsr = {24'd0, code} | ((ty == 1 && v6) ? 32'h800 : 32'h0); m_dfar = ea;
        chk(dabort && !pabort, "R7 dabort", {pabort, dabort}, 2'b01);
      end
    end
    chk_regs();
    @(negedge clk);
    chk(rsp_valid == 0 && !pabort && !dabort, "R9 one cycle", {rsp_valid, pabort, dabort}, 0);
    chk(!busy && !mpu_go && !walk_go, "R10 idle", {busy, mpu_go, walk_go}, 0);
    chk_regs();
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!rsp_valid && !busy && !pabort && !dabort, "R8 reset outs", {rsp_valid, busy}, 0);
    chk_regs();
    // R1 R2 bypass with relocation, at and below the limit
    run(32'h0123_4567, 0, 0, 32'h0, 32'h0400_0000, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    run(32'h01FF_FFFF, 1, 1, 32'h0, 32'h1000_0000, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    run(32'h0200_0000, 0, 0, 32'h0, 32'h1000_0000, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R3 R5 region checker success
    run(32'h3456_7ABC, 0, 1, 32'h1, 32'h0, 1, 0, 2, 0, 0, 32'h89AB_CDEF, 1, 0, 0);
    // R4 R6 old-format walk, fetch fault
    run(32'h0000_1234, 2, 0, 32'h1, 32'h0200_0000, 0, 1, 3, 1, 8'h95, 0, 0, 0, 0);
    // R4 R7 new-format walk, write fault with newer arch
    run(32'h7000_0010, 1, 1, 32'h0080_0001, 32'h0, 0, 1, 1, 1, 8'h2D, 0, 0, 0, 0);
    // R7 write fault without newer arch
    run(32'h7100_0020, 1, 0, 32'h1, 32'h0, 0, 0, 0, 1, 8'h0F, 0, 0, 0, 0);
    // R7 kind 3 treated as read, region checker, zero latency
    run(32'h0000_0400, 3, 0, 32'h1, 32'h0000_1000, 1, 1, 0, 1, 8'h41, 0, 0, 0, 0);
    // R10 request held while busy
    run(32'hABCD_0000, 0, 0, 32'h0080_0001, 32'h0, 0, 1, 4, 0, 0, 32'h1234_5678, 1, 1, 1);
    // R8 success after faults keeps registers
    run(32'h5555_5555, 2, 0, 32'h1, 32'h0, 1, 1, 1, 0, 0, 32'hFFFF_FFFF, 1, 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule